// File: doc/BRIEF.md
# Instruction-Phased Serial Register Port

This block is a serial slave port that lets an external controller read and write a small bank of internal registers over a clock, a chip-select, a data input and one of two data outputs. The controller starts every transaction with an instruction byte. That byte carries a read/write flag and a 4-bit register address. A data phase then follows, and its length in bytes is set by the register being addressed. After the last byte of that phase, the port expects a fresh instruction.

All serial inputs are brought into a faster system clock through two-flop synchronisers. Serial clock edges are found there by edge detection. Serial writes land in a staging copy of the register bank. A single-cycle update pulse copies the whole staging bank into the active bank, which the rest of the chip reads through a select/value lookup.

Two configuration bits in the active copy of register 7 control the port itself. One selects the bit order and the other selects the read-data pin. The chosen bit order covers the instruction byte as well as the data bytes. A dedicated port-reset input restores framing without touching any register.

Top module: `sport_regport`

## Requirements
- R1: The first eight serial clock rising edges of a transaction form the instruction byte. Its bit 7 set means read and clear means write. Bits 6..4 are ignored. Bits 3..0 are the register address.
- R2: The data phase lasts a fixed number of bytes per address: 6 bytes for addresses 2, 3 and 4; 4 bytes for addresses 5 and 7; 3 bytes for address 6; 2 bytes for addresses 0, 1, 8, 10 and 11.
- R3: Write data is sampled on serial clock rising edges. When MSB-first order is selected, the first data byte is the most significant byte of the register and each byte arrives MSB first. When LSB-first order is selected, the first byte is the least significant byte and each byte arrives LSB first. Each complete byte is stored into the staging copy.
- R4: Once the last data byte completes, the next eight rising edges are decoded as a new instruction, so surplus clocks are never taken as extra data.
- R5: A read returns the staging contents in the same byte and bit order as R3. Each output bit changes only after a serial clock falling edge and holds through the following high phase.
- R6: While chip-select (active low) is high, both output enables are low and the transaction is frozen. It resumes at the same bit once chip-select returns low.
- R7: While the port reset is high, the current transaction ends and the port waits for an instruction. A partial byte is discarded, and bytes already stored are kept.
- R8: Bit 1 of active register 7 selects LSB-first order when set and MSB-first order when clear, and the instruction byte follows that order too.
- R9: When bit 0 of active register 7 is clear, read data is driven on the shared pin (`sdio_o`, `sdio_oe_o`) and `sdo_oe_o` stays low. When the bit is set, read data is driven on `sdo_o` and `sdio_oe_o` stays low.
- R10: A one-cycle `update_i` pulse copies every staging register into the active copy. `act_val_o` shows the active copy of the register chosen by `act_sel_i`. The port configuration is taken only from the active copy.
- R11: Addresses 9 and 12..15 run a 2-byte data phase. Writes to them are discarded and reads of them return zero.
- R12: After system reset, all registers read zero, which gives MSB-first order on the shared pin, and both output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| sclk_i | input | 1 | Serial clock from the controller |
| cs_n_i | input | 1 | Active-low chip-select |
| sdata_i | input | 1 | Serial data into the port |
| port_rst_i | input | 1 | Active-high framing reset, leaves registers intact |
| update_i | input | 1 | One-cycle pulse copying staging to active registers |
| act_sel_i | input | 4 | Address of the active register to show |
| act_val_o | output | 48 | Active contents of the selected register, zero-extended |
| sdio_o | output | 1 | Read data on the shared data pin |
| sdio_oe_o | output | 1 | Output enable for the shared data pin |
| sdo_o | output | 1 | Read data on the separate output pin |
| sdo_oe_o | output | 1 | Output enable for the separate output pin |

## Verification
The embedded properties guard the framing on every cycle:
- the move from instruction to data after eight edges and the return to instruction after the last byte;
- the bound on the byte index;
- the freeze while deselected;
- the resync under port reset;
- output data moving only on falling edges;
- the update copy, and undefined addresses staying empty.

Bit and byte ordering, the surplus-clock reinterpretation, partial-byte loss under port reset, and the switch of order and pin only after an update are end-to-end effects. Only the bench's serial transactions and read-backs can show them.

// File: rtl/sport_pkg.sv
package sport_pkg;

  localparam int SP_AW   = 4;             // register address width
  localparam int SP_MAXB = 6;             // widest register in bytes
  localparam int SP_RW   = 8 * SP_MAXB;   // register storage width
  localparam int SP_NREG = 1 << SP_AW;

  typedef enum logic {PH_INSTR, PH_DATA} sp_phase_e;

  // R2/R11: data-phase length per address
  function automatic logic [2:0] sp_nbytes(input logic [SP_AW-1:0] a);
    case (a)
      4'd2, 4'd3, 4'd4: return 3'd6;
      4'd5, 4'd7:       return 3'd4;
      4'd6:             return 3'd3;
      default:          return 3'd2;
    endcase
  endfunction

  // R11: addresses that hold storage
  function automatic logic sp_defined(input logic [SP_AW-1:0] a);
    return (a <= 4'd8) || (a == 4'd10) || (a == 4'd11);
  endfunction

  // R3/R5/R8: register bit index of the seq-th transferred data bit
  function automatic logic [5:0] sp_bitpos(input logic [5:0] seq,
                                           input logic [2:0] n,
                                           input logic lsb);
    return lsb ? seq : ({n, 3'b000} - 6'd1 - seq);
  endfunction

endpackage

// File: rtl/sport_sync.sv
module sport_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         rise0,
  output logic         fall0
);
  logic [W-1:0] prev;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] sh;
    always_ff @(posedge clk) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[0], d[i]};
    end
    assign q[i] = sh[1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '0;
    else        prev <= q;
  end

  // edge events on bit 0 (serial clock)
  assign rise0 = q[0] & ~prev[0];
  assign fall0 = ~q[0] & prev[0];
endmodule

// File: rtl/sport_frame.sv
module sport_frame
  import sport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             fall,
  input  logic             hold,
  input  logic             prst,
  input  logic             din,
  input  logic             lsb,
  input  logic             rd_bit,
  output sp_phase_e        phase,
  output logic             is_rd,
  output logic [SP_AW-1:0] addr,
  output logic [5:0]       rd_pos,
  output logic             wr_en,
  output logic [2:0]       wr_slot,
  output logic [7:0]       wr_byte,
  output logic             dout
);
  sp_phase_e  phase_q;
  logic [2:0] bit_q, byte_q, n;
  logic [7:0] acc_q, acc_nxt;
  logic [2:0] place;
  logic       step, last_bit, last_byte;

  assign step      = rise & ~hold & ~prst;
  assign n         = sp_nbytes(addr);
  assign last_bit  = (bit_q == 3'd7);
  assign last_byte = (byte_q == n - 3'd1);

  // R8: bit order applies to instruction and data bits alike
  assign place = lsb ? bit_q : 3'd7 - bit_q;
  always_comb begin
    acc_nxt        = acc_q;
    acc_nxt[place] = din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_INSTR;
      bit_q   <= '0;
      byte_q  <= '0;
      acc_q   <= '0;
      is_rd   <= 1'b0;
      addr    <= '0;
    end else if (prst) begin            // R7: resync framing only
      phase_q <= PH_INSTR;
      bit_q   <= '0;
      byte_q  <= '0;
      acc_q   <= '0;
    end else if (step) begin
      bit_q <= bit_q + 3'd1;
      acc_q <= last_bit ? 8'h00 : acc_nxt;
      if (last_bit) begin
        if (phase_q == PH_INSTR) begin  // R1
          is_rd   <= acc_nxt[7];
          addr    <= acc_nxt[SP_AW-1:0];
          phase_q <= PH_DATA;
          byte_q  <= '0;
        end else if (last_byte) begin   // R4
          phase_q <= PH_INSTR;
          byte_q  <= '0;
        end else begin
          byte_q <= byte_q + 3'd1;
        end
      end
    end
  end

  // R5: read bit moves only on a falling edge
  always_ff @(posedge clk) begin
    if (!rst_n) dout <= 1'b0;
    else if (fall && !hold && !prst && phase_q == PH_DATA && is_rd) dout <= rd_bit;
  end

  assign phase   = phase_q;
  assign rd_pos  = sp_bitpos({byte_q, bit_q}, n, lsb);
  // R3/R11: store each complete byte, discard for undefined addresses
  assign wr_en   = step & last_bit & (phase_q == PH_DATA) & ~is_rd & sp_defined(addr);
  assign wr_slot = lsb ? byte_q : n - 3'd1 - byte_q;
  assign wr_byte = acc_nxt;

  a_r1_instr_to_data: assert property (@(posedge clk) disable iff (!rst_n)
    step && phase_q == PH_INSTR && last_bit |=> phase_q == PH_DATA && byte_q == 3'd0);
  a_r4_last_byte_ends: assert property (@(posedge clk) disable iff (!rst_n)
    step && phase_q == PH_DATA && last_bit && last_byte |=> phase_q == PH_INSTR);
  a_r2_byte_bound: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_DATA |-> byte_q < n);
  a_r6_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    hold && !prst |=> $stable(bit_q) && $stable(byte_q) && $stable(phase_q));
  a_r7_resync: assert property (@(posedge clk) disable iff (!rst_n)
    prst |=> phase_q == PH_INSTR && bit_q == 3'd0);
  a_r5_out_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(dout));
endmodule

// File: rtl/sport_regs.sv
module sport_regs
  import sport_pkg::*;
#(
  parameter int NREG = SP_NREG,
  parameter int RW   = SP_RW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SP_AW-1:0] wr_addr,
  input  logic [2:0]       wr_slot,
  input  logic [7:0]       wr_byte,
  input  logic             upd,
  input  logic [SP_AW-1:0] rd_addr,
  input  logic [5:0]       rd_pos,
  input  logic [SP_AW-1:0] act_sel,
  output logic             rd_bit,
  output logic [RW-1:0]    act_val,
  output logic [1:0]       cfg
);
  logic [RW-1:0] stg_q [NREG];
  logic [RW-1:0] act_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    // R12: zero after reset; R10: bulk copy on update
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stg_q[g] <= '0;
        act_q[g] <= '0;
      end else begin
        if (wr_en && wr_addr == g) stg_q[g][{wr_slot, 3'b000} +: 8] <= wr_byte;
        if (upd) act_q[g] <= stg_q[g];
      end
    end

    a_r10_update_copy: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> act_q[g] == $past(stg_q[g]));

    if (!sp_defined(g)) begin : g_undef
      a_r11_no_storage: assert property (@(posedge clk) disable iff (!rst_n)
        stg_q[g] == '0);
    end
  end

  assign rd_bit  = stg_q[rd_addr][rd_pos] & sp_defined(rd_addr);
  assign act_val = act_q[act_sel];
  assign cfg     = act_q[7][1:0];   // R8 bit 1 order, R9 bit 0 pin
endmodule

// File: rtl/sport_regport.sv
module sport_regport
  import sport_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_i,
  input  logic         cs_n_i,
  input  logic         sdata_i,
  input  logic         port_rst_i,
  input  logic         update_i,
  input  logic [3:0]   act_sel_i,
  output logic [47:0]  act_val_o,
  output logic         sdio_o,
  output logic         sdio_oe_o,
  output logic         sdo_o,
  output logic         sdo_oe_o
);
  logic [3:0]       sq;
  logic             s_rise, s_fall, hold, din, prst;
  sp_phase_e        phase;
  logic             is_rd, wr_en, rd_bit, dout, rd_active;
  logic [SP_AW-1:0] addr;
  logic [5:0]       rd_pos;
  logic [2:0]       wr_slot;
  logic [7:0]       wr_byte;
  logic [1:0]       cfg;

  sport_sync #(.W(4)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({port_rst_i, sdata_i, cs_n_i, sclk_i}),
    .q(sq), .rise0(s_rise), .fall0(s_fall));

  assign hold = sq[1];
  assign din  = sq[2];
  assign prst = sq[3];

  sport_frame u_frame (
    .clk(clk), .rst_n(rst_n), .rise(s_rise), .fall(s_fall), .hold(hold),
    .prst(prst), .din(din), .lsb(cfg[1]), .rd_bit(rd_bit), .phase(phase),
    .is_rd(is_rd), .addr(addr), .rd_pos(rd_pos), .wr_en(wr_en),
    .wr_slot(wr_slot), .wr_byte(wr_byte), .dout(dout));

  sport_regs #(.NREG(SP_NREG), .RW(SP_RW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(addr),
    .wr_slot(wr_slot), .wr_byte(wr_byte), .upd(update_i), .rd_addr(addr),
    .rd_pos(rd_pos), .act_sel(act_sel_i), .rd_bit(rd_bit),
    .act_val(act_val_o), .cfg(cfg));

  // R6/R9: drive only during an unpaused read data phase, on the chosen pin
  assign rd_active = (phase == PH_DATA) & is_rd & ~hold & ~prst;
  assign sdio_oe_o = rd_active & ~cfg[0];
  assign sdo_oe_o  = rd_active & cfg[0];
  assign sdio_o    = sdio_oe_o & dout;
  assign sdo_o     = sdo_oe_o & dout;

  a_r9_one_pin: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sdio_oe_o, sdo_oe_o}));
  a_r6_hiz_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !sdio_oe_o && !sdo_oe_o);
endmodule

// File: tb/sport_regport_bench.sv
module sport_regport_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int NB [16] = '{2,2,6,6,6,4,3,4,2,2,2,2,2,2,2,2};
  localparam logic [3:0]  VA [6] = '{4'h0, 4'h2, 4'h5, 4'h6, 4'h8, 4'hB};
  localparam logic [47:0] VD [6] = '{48'hFFFF_FFFF_1234, 48'h0123_4567_89AB,
                                    48'hAAAA_DEAD_BEEF, 48'h0000_00C3_5A96,
                                    48'h0000_0000_8001, 48'h1111_1111_7E42};

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, csn = 1'b1, sdin = 1'b0;
  logic prst = 1'b0, upd = 1'b0;
  logic [3:0]  act_sel = 4'h0;
  logic [47:0] act_val;
  logic sdio_o, sdio_oe, sdo_o, sdo_oe;
  int checks = 0, fails = 0;
  logic cur_lsb = 1'b0, cur_pin = 1'b0, bad_pin = 1'b0, saw_sdo = 1'b0, done = 1'b0;

  sport_regport u_sport_regport (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(csn), .sdata_i(sdin),
    .port_rst_i(prst), .update_i(upd), .act_sel_i(act_sel), .act_val_o(act_val),
    .sdio_o(sdio_o), .sdio_oe_o(sdio_oe), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [47:0] got, input logic [47:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [47:0] mask(input int n);
    return (48'h1 << (8 * n)) - 48'h1;
  endfunction

  task automatic sbit(input logic b, output logic r);
    sdin = b;
    wait_clk(HALF);
    r = cur_pin ? sdo_o : sdio_o;
    if (cur_pin ? sdio_oe : sdo_oe) bad_pin = 1'b1;
    if (sdo_oe) saw_sdo = 1'b1;
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
  endtask

  task automatic sbyte(input logic [7:0] v, output logic [7:0] r);
    r = '0;
    for (int j = 0; j < 8; j++) begin
      int p;
      logic b;
      p = cur_lsb ? j : 7 - j;
      sbit(v[p], b);
      r[p] = b;
    end
  endtask

  task automatic txn(input logic rd, input logic [3:0] a, input logic [47:0] w,
                     output logic [47:0] r);
    logic [7:0] junk, rb;
    int n;
    sbyte({rd, 3'b101, a}, junk);
    n = NB[a];
    r = '0;
    for (int k = 0; k < n; k++) begin
      int slot;
      slot = cur_lsb ? k : n - 1 - k;
      sbyte(w[slot*8 +: 8], rb);
      r[slot*8 +: 8] = rb;
    end
  endtask

  task automatic pulse_upd();
    upd = 1'b1;
    wait_clk(1);
    upd = 1'b0;
    wait_clk(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [47:0] r;
    logic [7:0]  rb;
    logic        v1, v2, v3;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    // R12 reset state
    chk("R12 sdio_oe after reset", {47'd0, sdio_oe}, 48'd0);
    chk("R12 sdo_oe after reset", {47'd0, sdo_oe}, 48'd0);
    act_sel = 4'h7; wait_clk(1);
    chk("R12 active reg7 zero", act_val, 48'd0);
    csn = 1'b0;
    wait_clk(4);

    // Vector table: R1 R2 R3 R5 R10
    for (int i = 0; i < 6; i++) begin
      txn(1'b0, VA[i], VD[i], r);
      txn(1'b1, VA[i], 48'd0, r);
      chk("R3 R2 readback", r, VD[i] & mask(NB[VA[i]]));
      act_sel = VA[i]; wait_clk(1);
      chk("R10 active before update", act_val, 48'd0);
      pulse_upd();
      chk("R10 active after update", act_val, VD[i] & mask(NB[VA[i]]));
    end

    // R4 surplus byte becomes a read instruction of address 8
    sbyte(8'h00, rb); sbyte(8'h56, rb); sbyte(8'h78, rb);
    sbyte(8'h88, rb);
    sbyte(8'h00, rb); r[15:8] = rb;
    sbyte(8'h00, rb); r[7:0] = rb;
    chk("R4 surplus decoded as instruction", {32'd0, r[15:0]}, 48'h8001);
    txn(1'b1, 4'h0, 48'd0, r);
    chk("R4 addr0 holds two bytes", r, 48'h5678);

    // R11 undefined address
    txn(1'b0, 4'h9, 48'hBEEF, r);
    txn(1'b1, 4'h9, 48'd0, r);
    chk("R11 undefined reads zero", r, 48'd0);
    txn(1'b1, 4'h0, 48'd0, r);
    chk("R11 framing kept after undefined", r, 48'h5678);

    // R6 suspend during a write
    sbyte(8'h01, rb); sbyte(8'hA5, rb);
    for (int j = 0; j < 3; j++) sbit((8'h5A >> (7 - j)) & 1'b1, v1);
    csn = 1'b1; wait_clk(4);
    for (int j = 0; j < 3; j++) sbit(1'b1, v1);
    chk("R6 no drive while deselected", {46'd0, sdio_oe, sdo_oe}, 48'd0);
    csn = 1'b0; wait_clk(4);
    for (int j = 3; j < 8; j++) sbit((8'h5A >> (7 - j)) & 1'b1, v1);
    txn(1'b1, 4'h1, 48'd0, r);
    chk("R6 write resumed intact", r, 48'hA55A);

    // R6 suspend during a read, R1 read direction enables the shared pin
    sbyte(8'h81, rb);
    wait_clk(HALF);
    chk("R1 read enables shared pin", {47'd0, sdio_oe}, 48'd1);
    csn = 1'b1; wait_clk(4);
    chk("R6 read output released", {46'd0, sdio_oe, sdo_oe}, 48'd0);
    csn = 1'b0; wait_clk(4);
    sbyte(8'h00, rb); r[15:8] = rb;
    sbyte(8'h00, rb); r[7:0] = rb;
    chk("R6 read resumed", {32'd0, r[15:0]}, 48'hA55A);

    // R5 output held through the high phase, moves after falling edge
    sbyte(8'h81, rb);
    sdin = 1'b0;
    wait_clk(HALF);
    v1 = sdio_o;
    sclk = 1'b1;
    wait_clk(HALF - 1);
    v2 = sdio_o;
    sclk = 1'b0;
    wait_clk(HALF);
    v3 = sdio_o;
    chk("R5 first bit", {47'd0, v1}, 48'd1);
    chk("R5 stable while high", {47'd0, v2}, 48'd1);
    chk("R5 next bit after fall", {47'd0, v3}, 48'd0);
    for (int j = 1; j < 16; j++) sbit(1'b0, v1);

    // R7 port reset mid-byte keeps the complete byte
    sbyte(8'h00, rb); sbyte(8'hCD, rb);
    for (int j = 0; j < 3; j++) sbit(1'b1, v1);
    prst = 1'b1; wait_clk(4);
    chk("R7 outputs idle in port reset", {46'd0, sdio_oe, sdo_oe}, 48'd0);
    prst = 1'b0; wait_clk(4);
    txn(1'b1, 4'h0, 48'd0, r);
    chk("R7 complete byte kept", r, 48'hCD78);

    // R10 config only after update; R8 LSB order; R9 separate pin
    txn(1'b0, 4'h7, 48'h3, r);
    txn(1'b1, 4'h1, 48'd0, r);
    chk("R10 staged config not yet applied", r, 48'hA55A);
    pulse_upd();
    cur_lsb = 1'b1; cur_pin = 1'b1; bad_pin = 1'b0; saw_sdo = 1'b0;
    txn(1'b0, 4'h5, 48'h0102_0304, r);
    txn(1'b1, 4'h5, 48'd0, r);
    chk("R8 LSB-first readback", r, 48'h0102_0304);
    act_sel = 4'h5;
    pulse_upd();
    chk("R8 LSB-first register value", act_val, 48'h0102_0304);
    txn(1'b1, 4'h7, 48'd0, r);
    chk("R8 reg7 read in LSB order", r, 48'h3);
    chk("R9 separate pin used", {47'd0, saw_sdo}, 48'd1);
    chk("R9 shared pin stayed off", {47'd0, bad_pin}, 48'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule